// File: doc/BRIEF.md
# End-of-Write Status Reporter

This block sits on the read-data path of a byte-wide nonvolatile memory. While the internal programming cycle runs, it lets a polling host see progress through ordinary reads. The write sequencer supplies a busy flag and the last byte it accepted. The array supplies its read data, and the host supplies its chip-enable and output-enable strobes, both active low.

While busy, any read returns a status byte instead of array contents. Bit 7 carries the inverse of the last written bit 7. Bit 6 flips once per read access. Bits 5 to 0 repeat the last written data. When the block is idle, reads return the array byte unchanged.

Whether a read returns status or data is decided when the read access starts. That choice holds until the strobes are released. A write-permit output stays low while busy and for a set number of clock cycles after busy falls.

Top module: `eow_status`

## Requirements
- R1: `dq_oe_o` is high only while both `ce_n_i` and `oe_n_i` are low, and `dq_o` is 8'h00 whenever `dq_oe_o` is low.
- R2: A read access that starts while `busy_i` is low returns `array_data_i` on `dq_o`.
- R3: A read access that starts while `busy_i` is high returns the inverse of `last_data_i[7]` on `dq_o[7]`.
- R4: A read access starts on the cycle the combined strobe (both enables low) first becomes active. Each start while busy inverts the bit 6 value, and a read held active for many cycles inverts it only once.
- R5: During a busy read, `dq_o[5:0]` equals `last_data_i[5:0]` and does not depend on `array_data_i`.
- R6: After reset the toggle state is 0, so the first busy read returns `dq_o[6]` = 1.
- R7: The status or data choice is fixed at read start. If `busy_i` falls during an active read, `dq_o` keeps the status byte until the strobes are released, and the next read returns array data.
- R8: `write_ok_o` is low while `busy_i` is high. After `busy_i` falls, it goes high on the RECOVERY_CYCLES-th rising clock edge, counted from the first edge that samples `busy_i` low. It is high out of reset.
- R9: Reads that start while idle leave the toggle state alone, so consecutive busy reads always show opposite values on bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Programming cycle in progress, from the write sequencer |
| last_data_i | input | 8 | Last byte accepted by the write sequencer |
| array_data_i | input | 8 | Array read data |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| dq_o | output | 8 | Byte driven to the data bus |
| dq_oe_o | output | 1 | Data bus drive enable |
| write_ok_o | output | 1 | New write may be accepted |

## Verification
The bench builds the block with RECOVERY_CYCLES set to 6. This puts the whole recovery window after busy falls within a few cycles, so the edge on which `write_ok_o` rises can be checked exactly. The other cases exercised are single-cycle reads, reads held low for several cycles, and busy falling in the middle of a read. They also cover idle reads placed between busy reads and strobes where only one enable is low.

// File: rtl/eow_status.sv
module eow_status #(
  parameter int RECOVERY_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy_i,
  input  logic [7:0] last_data_i,
  input  logic [7:0] array_data_i,
  input  logic       ce_n_i,
  input  logic       oe_n_i,
  output logic [7:0] dq_o,
  output logic       dq_oe_o,
  output logic       write_ok_o
);
  localparam int CW = (RECOVERY_CYCLES < 1) ? 1 : $clog2(RECOVERY_CYCLES + 1);
  localparam logic [CW-1:0] REC_LOAD = CW'(RECOVERY_CYCLES);

  logic          rd_act, rd_q, rd_start;
  logic          mode_q, tog_q;
  logic          eff_busy, eff_tog;
  logic [CW-1:0] rec_cnt;
  logic [7:0]    status_byte;

  assign rd_act   = ~ce_n_i & ~oe_n_i;
  assign rd_start = rd_act & ~rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      mode_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      rd_q <= rd_act;
      if (rd_start) begin
        mode_q <= busy_i;
        if (busy_i) tog_q <= ~tog_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rec_cnt <= '0;
    else if (busy_i)       rec_cnt <= REC_LOAD;
    else if (rec_cnt != 0) rec_cnt <= rec_cnt - CW'(1);
  end

  assign eff_busy    = rd_start ? busy_i : mode_q;
  assign eff_tog     = rd_start ? (tog_q ^ busy_i) : tog_q;
  assign status_byte = {~last_data_i[7], eff_tog, last_data_i[5:0]};

  assign dq_oe_o    = rd_act;
  assign dq_o       = !rd_act ? 8'h00 : (eff_busy ? status_byte : array_data_i);
  assign write_ok_o = ~busy_i & (rec_cnt == 0);
endmodule

// File: rtl/eow_status_chk.sv
module eow_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_i,
  input logic [7:0] last_data_i,
  input logic [7:0] array_data_i,
  input logic [7:0] dq_o,
  input logic       dq_oe_o,
  input logic       write_ok_o
);
  logic was_oe, seen, prev_b6;
  logic start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_oe <= 1'b0;
    else        was_oe <= dq_oe_o;
  end
  assign start = dq_oe_o & ~was_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      prev_b6 <= 1'b0;
    end else if (start && busy_i) begin
      seen    <= 1'b1;
      prev_b6 <= dq_o[6];
    end
  end

  assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe_o |-> dq_o == 8'h00);

  assert_poll_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_i) |-> dq_o[7] == ~last_data_i[7]);

  assert_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_i) |-> dq_o[5:0] == last_data_i[5:0]);

  assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_i && seen) |-> dq_o[6] != prev_b6);

  assert_hold_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe_o && was_oe && $stable(array_data_i) && $stable(last_data_i)) |-> $stable(dq_o));

  assert_no_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !write_ok_o);

  assert_recover_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_i) |-> !write_ok_o);
endmodule

bind eow_status eow_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .last_data_i(last_data_i),
  .array_data_i(array_data_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .write_ok_o(write_ok_o)
);

// File: tb/tb_eow_status.sv
`timescale 1ns/100ps
module tb_eow_status;
  localparam int REC = 6;
  localparam logic [24:0] VEC [0:7] = '{
    {1'b0, 8'h00, 8'hA5, 8'hA5},
    {1'b1, 8'h3C, 8'hFF, 8'hFC},
    {1'b1, 8'h3C, 8'h00, 8'hBC},
    {1'b0, 8'h3C, 8'h5A, 8'h5A},
    {1'b1, 8'hC1, 8'h77, 8'h41},
    {1'b1, 8'hC1, 8'h77, 8'h01},
    {1'b1, 8'h80, 8'h12, 8'h40},
    {1'b0, 8'h80, 8'h80, 8'h80}
  };

  logic clk = 0, rst_n = 0, busy = 0, ce_n = 1, oe_n = 1;
  logic [7:0] last = 0, arr = 0, dq;
  logic dq_oe, wok;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  eow_status #(.RECOVERY_CYCLES(REC)) dut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .last_data_i(last), .array_data_i(arr),
    .ce_n_i(ce_n), .oe_n_i(oe_n), .dq_o(dq), .dq_oe_o(dq_oe), .write_ok_o(wok));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic start_read;
    @(negedge clk); ce_n = 0; oe_n = 0; #1;
  endtask

  task automatic end_read;
    @(negedge clk); ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(100000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset oe", {7'd0, dq_oe}, 8'h00);
    chk("R1 reset dq", dq, 8'h00);
    chk("R8 reset write_ok", {7'd0, wok}, 8'h01);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      busy = VEC[i][24]; last = VEC[i][23:16]; arr = VEC[i][15:8];
      start_read();
      chk($sformatf("R2/R3/R4/R5/R6 vector %0d", i), dq, VEC[i][7:0]);
      end_read();
    end

    busy = 1; last = 8'h15; arr = 8'h99;
    start_read();
    chk("R4 held read first", dq, 8'h95);
    repeat (4) @(negedge clk);
    #1 chk("R4 held read stays", dq, 8'h95);
    end_read();
    start_read();
    chk("R4 next read toggles once", dq, 8'hD5);
    end_read();

    arr = 8'h3E;
    start_read();
    chk("R7 status at start", dq, 8'h95);
    @(negedge clk); busy = 0;
    repeat (2) @(negedge clk);
    #1 chk("R7 status kept after busy falls", dq, 8'h95);
    end_read();
    start_read();
    chk("R7 next read is array data", dq, 8'h3E);
    end_read();
    busy = 1;
    start_read();
    chk("R9 idle read left toggle alone", dq, 8'hD5);
    end_read();

    busy = 0;
    @(negedge clk); ce_n = 0; oe_n = 1; #1;
    chk("R1 ce only oe", {7'd0, dq_oe}, 8'h00);
    chk("R1 ce only dq", dq, 8'h00);
    @(negedge clk); ce_n = 1; oe_n = 0; #1;
    chk("R1 oe only oe", {7'd0, dq_oe}, 8'h00);
    chk("R1 oe only dq", dq, 8'h00);
    @(negedge clk); oe_n = 1;

    busy = 1;
    repeat (3) @(negedge clk);
    chk("R8 busy blocks write", {7'd0, wok}, 8'h00);
    busy = 0;
    for (int k = 1; k <= REC; k++) begin
      @(negedge clk);
      chk($sformatf("R8 recovery edge %0d", k), {7'd0, wok}, (k == REC) ? 8'h01 : 8'h00);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule